// File: doc/BRIEF.md
# Operand Address Generator

This block turns an operand-addressing request into a 24-bit operand address. A request carries a mode code, a register number, an operand size, the current value of the named address register, up to two extension words and the address at which the first extension word sits. The block returns the operand address and the new value for the address register. It also returns a flag that says whether that register must be written back, and a flag that marks a misaligned word or longword access. The caller reads the register file, fetches the extension words and performs the memory access.

Requests enter through a valid/ready pair and results leave through a second valid/ready pair, with one register stage between them. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result shows on the outputs from the next cycle and stays unchanged until a clock edge where `out_ready` is high. The input side is ready whenever the output stage is empty or is being emptied in the same cycle, so a consumer that holds `out_ready` high gets one result per cycle. The indexed modes need a second register value. The block decodes which register that is from the first extension word and shows the choice on plain outputs. The caller returns that register's value on `idx_val` in the same cycle.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `in_ready` is 1 until a request is taken.
- R2: `in_ready` equals (not `out_valid`) or `out_ready`. A request taken at an edge appears on the outputs after that edge. While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R3: Mode 0 (register indirect): the address is the register value and write-back is 0.
- R4: Mode 1 (post-increment): the address is the register value before the step. The new register value is that value plus the step, and write-back is 1. The size codes are 0 byte, 1 word, 2 long and 3 long, giving steps of 1, 2, 4 and 4.
- R5: Mode 2 (pre-decrement): the new register value is the register value minus the step. The address is that decremented value, and write-back is 1.
- R6: When the register number is 7 and the size is byte, the step for modes 1 and 2 is 2 rather than 1.
- R7: Mode 3: the address is the register plus the sign-extended 16-bit first extension word.
- R8: Mode 4 (indexed) uses the first extension word. Bit 15 selects a data (0) or address (1) register and drives `idx_bank`. Bits 14..12 give its number and drive `idx_num`. Bit 11 selects a sign-extended low 16 bits of `idx_val` (0) or all 32 bits (1). Bits 7..0 are a signed displacement. The address is the register plus the index plus the displacement.
- R9: Mode 5: the address is the sign-extended first extension word, so 0x8000 gives 0xFF8000.
- R10: Mode 6: the address is the first extension word as the high half and the second as the low half.
- R11: Modes 7 and 8 act as modes 3 and 4, but `in_ext_pc` takes the place of the register as the base.
- R12: `out_odd` is 1 exactly when the size is not byte and the address bit 0 is 1.
- R13: Mode codes 9 to 15 give address 0, write-back 0, `out_odd` 0 and the register value unchanged.
- R14: The address keeps only the low 24 bits of the 32-bit sum. `out_areg` carries all 32 bits. In modes other than 1 and 2, `out_areg` equals the input register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_mode | input | 4 | Addressing mode code |
| in_size | input | 2 | Operand size code |
| in_reg | input | 3 | Address register number |
| in_areg | input | 32 | Value of the named address register |
| in_ext0 | input | 16 | First extension word |
| in_ext1 | input | 16 | Second extension word |
| in_ext_pc | input | 32 | Address of the first extension word |
| idx_bank | output | 1 | Index register bank: 0 data, 1 address |
| idx_num | output | 3 | Index register number |
| idx_val | input | 32 | Value of the selected index register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 24 | Operand address |
| out_areg | output | 32 | Updated address register value |
| out_wb | output | 1 | Register write-back required |
| out_odd | output | 1 | Misaligned word or longword access |

## Verification
Two of this block's functions can fall in the same cycle: the output stage releases a held result and accepts the next request at the same edge. This is provoked by stalling `out_ready` for several cycles while a second request waits, then raising it. Streaming runs with `out_ready` constantly high give the same overlap. A behavioural queue in the bench predicts the outputs for every cycle. It is judged on each cycle by comparing `in_ready`, `out_valid` and the result fields against that queue. The queue pops and pushes in one step at such an edge, and any lost, doubled or changed result shows as a mismatch.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;
  typedef enum logic [3:0] {
    EA_IND     = 4'd0,
    EA_POST    = 4'd1,
    EA_PRE     = 4'd2,
    EA_DISP    = 4'd3,
    EA_INDEX   = 4'd4,
    EA_ABSW    = 4'd5,
    EA_ABSL    = 4'd6,
    EA_PCDISP  = 4'd7,
    EA_PCINDEX = 4'd8
  } ea_mode_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/ea_step.sv
`timescale 1ns/1ps
module ea_step #(
  parameter int REG_W  = 32,
  parameter int RNUM_W = 3,
  parameter int SP_REG = 7
) (
  input  logic [1:0]        size,
  input  logic [RNUM_W-1:0] reg_num,
  output logic [REG_W-1:0]  step
);
  import ea_pkg::*;
  localparam logic [RNUM_W-1:0] SP_NUM = RNUM_W'(SP_REG);

  always_comb begin
    case (size)
      SZ_BYTE: step = (reg_num == SP_NUM) ? REG_W'(2) : REG_W'(1);
      SZ_WORD: step = REG_W'(2);
      default: step = REG_W'(4);
    endcase
  end

  // stack pointer must stay even whatever the size (R6)
  always_comb begin
    if (reg_num == SP_NUM) begin
      p_sp_even_r6: assert (step[0] == 1'b0);
    end
  end
endmodule

// File: rtl/ea_index.sv
`timescale 1ns/1ps
module ea_index #(
  parameter int REG_W  = 32,
  parameter int EXT_W  = 16,
  parameter int RNUM_W = 3,
  parameter int DISP_W = 8
) (
  input  logic [EXT_W-1:0]  ext,
  input  logic [REG_W-1:0]  idx_val,
  output logic              idx_bank,
  output logic [RNUM_W-1:0] idx_num,
  output logic [REG_W-1:0]  offset
);
  localparam int BANK_BIT = EXT_W - 1;
  localparam int NUM_MSB  = BANK_BIT - 1;
  localparam int LONG_BIT = NUM_MSB - RNUM_W;

  logic [REG_W-1:0] idx_scaled;
  logic [REG_W-1:0] disp_ext;

  assign idx_bank = ext[BANK_BIT];
  assign idx_num  = ext[NUM_MSB -: RNUM_W];

  always_comb begin
    if (ext[LONG_BIT])
      idx_scaled = idx_val;
    else
      idx_scaled = {{(REG_W-EXT_W){idx_val[EXT_W-1]}}, idx_val[EXT_W-1:0]};
    disp_ext = {{(REG_W-DISP_W){ext[DISP_W-1]}}, ext[DISP_W-1:0]};
    offset   = idx_scaled + disp_ext;
  end
endmodule

// File: rtl/ea_core.sv
`timescale 1ns/1ps
module ea_core #(
  parameter int REG_W = 32,
  parameter int EXT_W = 16
) (
  input  ea_pkg::ea_mode_e  mode,
  input  logic [REG_W-1:0]  a_val,
  input  logic [REG_W-1:0]  pc_val,
  input  logic [EXT_W-1:0]  ext0,
  input  logic [EXT_W-1:0]  ext1,
  input  logic [REG_W-1:0]  step,
  input  logic [REG_W-1:0]  idx_off,
  output logic [REG_W-1:0]  sum,
  output logic [REG_W-1:0]  new_a,
  output logic              wb
);
  import ea_pkg::*;

  logic [REG_W-1:0] disp16;
  logic [REG_W-1:0] abs_long;

  assign disp16   = {{(REG_W-EXT_W){ext0[EXT_W-1]}}, ext0};
  assign abs_long = REG_W'({ext0, ext1});

  always_comb begin
    sum   = '0;
    new_a = a_val;
    wb    = 1'b0;
    case (mode)
      EA_IND:     sum = a_val;
      EA_POST: begin
        sum   = a_val;
        new_a = a_val + step;
        wb    = 1'b1;
      end
      EA_PRE: begin
        new_a = a_val - step;
        sum   = new_a;
        wb    = 1'b1;
      end
      EA_DISP:    sum = a_val + disp16;
      EA_INDEX:   sum = a_val + idx_off;
      EA_ABSW:    sum = disp16;
      EA_ABSL:    sum = abs_long;
      EA_PCDISP:  sum = pc_val + disp16;
      EA_PCINDEX: sum = pc_val + idx_off;
      default:    sum = '0;
    endcase
  end

  // pre-decrement addresses the decremented register (R5)
  always_comb begin
    if (mode == EA_PRE) begin
      p_pre_addr_r5: assert (sum == a_val - step);
    end
  end
endmodule

// File: rtl/ea_gen.sv
`timescale 1ns/1ps
module ea_gen #(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 32,
  parameter int EXT_W  = 16,
  parameter int RNUM_W = 3,
  parameter int SP_REG = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_mode,
  input  logic [1:0]        in_size,
  input  logic [RNUM_W-1:0] in_reg,
  input  logic [REG_W-1:0]  in_areg,
  input  logic [EXT_W-1:0]  in_ext0,
  input  logic [EXT_W-1:0]  in_ext1,
  input  logic [REG_W-1:0]  in_ext_pc,
  output logic              idx_bank,
  output logic [RNUM_W-1:0] idx_num,
  input  logic [REG_W-1:0]  idx_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [REG_W-1:0]  out_areg,
  output logic              out_wb,
  output logic              out_odd
);
  import ea_pkg::*;

  ea_mode_e         mode_c;
  logic [REG_W-1:0] step_c;
  logic [REG_W-1:0] idx_off_c;
  logic [REG_W-1:0] sum_c;
  logic [REG_W-1:0] new_a_c;
  logic             wb_c;
  logic             odd_c;
  logic             take;

  assign mode_c = ea_mode_e'(in_mode);

  ea_step #(.REG_W(REG_W), .RNUM_W(RNUM_W), .SP_REG(SP_REG)) u_step (
    .size(in_size), .reg_num(in_reg), .step(step_c)
  );

  ea_index #(.REG_W(REG_W), .EXT_W(EXT_W), .RNUM_W(RNUM_W)) u_index (
    .ext(in_ext0), .idx_val(idx_val), .idx_bank(idx_bank),
    .idx_num(idx_num), .offset(idx_off_c)
  );

  ea_core #(.REG_W(REG_W), .EXT_W(EXT_W)) u_core (
    .mode(mode_c), .a_val(in_areg), .pc_val(in_ext_pc), .ext0(in_ext0),
    .ext1(in_ext1), .step(step_c), .idx_off(idx_off_c),
    .sum(sum_c), .new_a(new_a_c), .wb(wb_c)
  );

  assign odd_c    = (in_size != SZ_BYTE) && sum_c[0];
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_areg  <= '0;
      out_wb    <= 1'b0;
      out_odd   <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_addr  <= sum_c[ADDR_W-1:0];
        out_areg  <= new_a_c;
        out_wb    <= wb_c;
        out_odd   <= odd_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
    $stable(out_areg) && $stable(out_wb) && $stable(out_odd));

  p_odd_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_odd |-> out_addr[0]);

  p_wb_mode_r13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_mode > 4'd8) |=> !out_wb && !out_odd && out_addr == '0);
endmodule

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_mode = '0;
  logic [1:0]  in_size = '0;
  logic [2:0]  in_reg = '0;
  logic [31:0] in_areg = '0;
  logic [15:0] in_ext0 = '0;
  logic [15:0] in_ext1 = '0;
  logic [31:0] in_ext_pc = '0;
  logic        idx_bank;
  logic [2:0]  idx_num;
  logic [31:0] idx_val;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_addr;
  logic [31:0] out_areg;
  logic        out_wb;
  logic        out_odd;

  logic [31:0] dregs [8];
  logic [31:0] aregs [8];

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;   // 0 always ready, 1 random, 2 stalled
  bit accepted;

  typedef struct {
    logic [23:0] addr;
    logic [31:0] areg;
    logic        wb;
    logic        odd;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  always #10 clk = ~clk;

  assign idx_val = in_ext0[15] ? aregs[in_ext0[14:12]] : dregs[in_ext0[14:12]];

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_size(in_size), .in_reg(in_reg), .in_areg(in_areg),
    .in_ext0(in_ext0), .in_ext1(in_ext1), .in_ext_pc(in_ext_pc),
    .idx_bank(idx_bank), .idx_num(idx_num), .idx_val(idx_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_areg(out_areg), .out_wb(out_wb), .out_odd(out_odd)
  );

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t ref_ea(logic [3:0] m, logic [1:0] sz, logic [2:0] rn,
                                  logic [31:0] a, logic [15:0] e0, logic [15:0] e1,
                                  logic [31:0] pc);
    exp_t r;
    logic [31:0] stp, iv, ea, sd16, sd8;
    stp  = (sz == 2'd0) ? ((rn == 3'd7) ? 32'd2 : 32'd1) : (sz == 2'd1) ? 32'd2 : 32'd4;
    sd16 = 32'($signed(e0));
    sd8  = 32'($signed(e0[7:0]));
    iv   = e0[15] ? aregs[e0[14:12]] : dregs[e0[14:12]];
    if (!e0[11]) iv = 32'($signed(iv[15:0]));
    r.areg = a;
    r.wb   = 1'b0;
    case (m)
      4'd0: begin ea = a; r.tag = "R3"; end
      4'd1: begin ea = a; r.areg = a + stp; r.wb = 1'b1;
                  r.tag = (rn == 3'd7 && sz == 2'd0) ? "R6" : "R4"; end
      4'd2: begin r.areg = a - stp; ea = r.areg; r.wb = 1'b1;
                  r.tag = (rn == 3'd7 && sz == 2'd0) ? "R6" : "R5"; end
      4'd3: begin ea = a + sd16; r.tag = "R7"; end
      4'd4: begin ea = a + iv + sd8; r.tag = "R8"; end
      4'd5: begin ea = sd16; r.tag = "R9"; end
      4'd6: begin ea = {e0, e1}; r.tag = "R10"; end
      4'd7: begin ea = pc + sd16; r.tag = "R11"; end
      4'd8: begin ea = pc + iv + sd8; r.tag = "R11"; end
      default: begin ea = 32'd0; r.tag = "R13"; end
    endcase
    r.addr = ea[23:0];          // R14: upper bits dropped
    r.odd  = (sz != 2'd0) && ea[0];
    return r;
  endfunction

  task automatic tick();
    bit exp_rdy;
    bit fire;
    #1;
    exp_rdy = (exp_q.size() == 0) || out_ready;
    chk(in_ready == exp_rdy, "R2", "in_ready", 32'(in_ready), 32'(exp_rdy));
    chk(idx_bank == in_ext0[15] && idx_num == in_ext0[14:12], "R8", "index select",
        {28'd0, idx_bank, idx_num}, {28'd0, in_ext0[15], in_ext0[14:12]});
    cur = ref_ea(in_mode, in_size, in_reg, in_areg, in_ext0, in_ext1, in_ext_pc);
    @(posedge clk);
    fire = in_valid && exp_rdy;
    if (exp_q.size() > 0 && out_ready) void'(exp_q.pop_front());
    if (fire) exp_q.push_back(cur);
    accepted = fire;
    @(negedge clk);
    chk(out_valid == (exp_q.size() > 0), "R2", "out_valid", 32'(out_valid), 32'(exp_q.size() > 0));
    if (exp_q.size() > 0 && out_valid) begin
      chk(out_addr == exp_q[0].addr, exp_q[0].tag, "address", 32'(out_addr), 32'(exp_q[0].addr));
      chk(out_areg == exp_q[0].areg && out_wb == exp_q[0].wb, exp_q[0].tag, "register/wb",
          out_areg ^ 32'(out_wb), exp_q[0].areg ^ 32'(exp_q[0].wb));
      chk(out_odd == exp_q[0].odd, "R12", "odd flag", 32'(out_odd), 32'(exp_q[0].odd));
    end
  endtask

  task automatic pick_ready(inout int stall_left);
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom % 2);
      default: begin
        out_ready = (stall_left == 0);
        if (stall_left > 0) stall_left--;
      end
    endcase
  endtask

  task automatic send(logic [3:0] m, logic [1:0] sz, logic [2:0] rn,
                      logic [15:0] e0, logic [15:0] e1, logic [31:0] pc);
    int stall = 4;
    in_mode = m; in_size = sz; in_reg = rn; in_areg = aregs[rn];
    in_ext0 = e0; in_ext1 = e1; in_ext_pc = pc;
    in_valid = 1'b1;
    do begin
      pick_ready(stall);
      tick();
    end while (!accepted);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      dregs[i] = 32'h0001_0000 * (i + 1) + 32'h0000_8000 + i;
      aregs[i] = 32'h0000_1000 * (i + 1);
    end
    dregs[2] = 32'h1234_FFF0;   // low half negative
    aregs[3] = 32'h0001_0005;
    aregs[5] = 32'h1234_5678;
    aregs[6] = 32'h00FF_FFFF;
    aregs[7] = 32'h0000_2000;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);

    // directed cases
    send(4'd0, 2'd1, 3'd5, 16'h0, 16'h0, 32'h0);       // R3, R14 truncation
    send(4'd1, 2'd1, 3'd2, 16'h0, 16'h0, 32'h0);       // R4 word
    send(4'd1, 2'd0, 3'd3, 16'h0, 16'h0, 32'h0);       // R4 byte, odd base
    send(4'd1, 2'd2, 3'd1, 16'h0, 16'h0, 32'h0);       // R4 long
    send(4'd1, 2'd3, 3'd1, 16'h0, 16'h0, 32'h0);       // R4 size code 3
    send(4'd1, 2'd1, 3'd6, 16'h0, 16'h0, 32'h0);       // R14 carry past 24 bits, R12 odd
    send(4'd2, 2'd2, 3'd4, 16'h0, 16'h0, 32'h0);       // R5 long
    send(4'd2, 2'd0, 3'd7, 16'h0, 16'h0, 32'h0);       // R6 predecrement
    send(4'd1, 2'd0, 3'd7, 16'h0, 16'h0, 32'h0);       // R6 postincrement
    send(4'd3, 2'd1, 3'd1, 16'hFFFE, 16'h0, 32'h0);    // R7 negative
    send(4'd3, 2'd1, 3'd1, 16'h0003, 16'h0, 32'h0);    // R7/R12 odd word
    send(4'd4, 2'd1, 3'd1, 16'h20F0, 16'h0, 32'h0);    // R8 data word index, disp -16
    send(4'd4, 2'd2, 3'd1, 16'hD804, 16'h0, 32'h0);    // R8 address long index
    send(4'd5, 2'd1, 3'd0, 16'h8000, 16'h0, 32'h0);    // R9 -> FF8000
    send(4'd5, 2'd0, 3'd0, 16'h7FFF, 16'h0, 32'h0);    // R9 byte odd, no flag
    send(4'd6, 2'd2, 3'd0, 16'h00AB, 16'hCDE0, 32'h0); // R10
    send(4'd7, 2'd1, 3'd0, 16'h0010, 16'h0, 32'h0000_4002); // R11 displacement
    send(4'd8, 2'd1, 3'd0, 16'hB880, 16'h0, 32'h0000_4002); // R11 index
    send(4'd9, 2'd1, 3'd5, 16'h1234, 16'h5678, 32'h9);      // R13
    send(4'd15, 2'd2, 3'd6, 16'hFFFF, 16'hFFFF, 32'h9);     // R13

    // R2: stall with a second request waiting, then release
    drain();
    rdy_mode = 2;
    send(4'd3, 2'd1, 3'd2, 16'h0100, 16'h0, 32'h0);
    send(4'd4, 2'd0, 3'd2, 16'hA801, 16'h0, 32'h0);
    drain();

    // streaming and random back-pressure
    for (int pass = 0; pass < 2; pass++) begin
      rdy_mode = pass;
      for (int n = 0; n < 300; n++) begin
        for (int i = 0; i < 8; i++) begin
          dregs[i] = $urandom;
          aregs[i] = $urandom;
        end
        send(4'($urandom % 16), 2'($urandom % 4), 3'($urandom % 8),
             16'($urandom), 16'($urandom), $urandom);
      end
      drain();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule